// File: doc/BRIEF.md
# Seven-bit reciprocal estimator

This block returns a coarse approximation of 1/x for a binary floating-point operand. The result carries seven meaningful significand bits and is meant as a cheap first guess for software or hardware refinement. The operand format is set by two parameters: the exponent field width and the fraction field width. Half (5/10), single (8/23) and double (11/52) layouts are the intended settings, and single is the default.

The unit is purely combinational. It first classifies the operand: NaN of either kind, infinity, zero, subnormal or normal. A subnormal operand is brought into normalised form with a leading-zero count. The top seven fraction bits then address a 128-entry table of reciprocal significands, which is computed when the design is elaborated. The output exponent follows from the bias. If that exponent drops to the bottom edge of the normal range, the output becomes a subnormal with the implicit one shifted in. Operands so tiny that the reciprocal cannot be represented are saturated. A 3-bit rounding-mode input, together with the operand sign, decides between infinity and the largest finite value. Exception flags are raised alongside the result.

Top module: `rec7_estimator`

## Requirements
- R1: An infinite operand gives a zero result of the same sign and raises no flags.
- R2: A zero operand gives an infinity of the same sign and raises only the divide-by-zero flag. The flag vector is bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact.
- R3: A signalling NaN (exponent all ones, fraction MSB clear, fraction nonzero) gives the canonical NaN and raises only invalid (bit 4). The canonical NaN has sign 0, exponent all ones and only the fraction MSB set. A quiet NaN (fraction MSB set) gives the canonical NaN with no flags.
- R4: For a normal operand with biased exponent e, the result keeps the sign and has exponent 2·B−1−e, where B = 2^(E−1)−1. Its fraction is the table entry selected by the top seven operand fraction bits, placed in the top seven result fraction bits, with all lower bits zero. The lower operand fraction bits and the rounding mode have no effect, and no flags are raised.
- R5: Table entry i (0..127) equals round(65536/(257+2i)) − 128. Entry 0 is 127 and entry 127 is 0, and the entries never increase with i.
- R6: A subnormal operand with fewer than two leading zeros in its fraction is normalised before lookup. Its exponent becomes minus the leading-zero count, and its fraction is shifted left by that count plus one. The result is then formed as in R4, with no flags.
- R7: When the computed exponent is 0, the result exponent is 0. Its fraction is the table-derived fraction shifted right by one, with bit S−1 set.
- R8: When the computed exponent is −1, the result exponent is 0. Its fraction is the table-derived fraction shifted right by two, with bit S−2 set.
- R9: A subnormal operand with two or more leading fraction zeros raises overflow and inexact (bits 2 and 0). The result is the largest finite value of the operand's sign in three cases: mode 1 (toward zero), mode 2 (downward) with a positive sign, and mode 3 (upward) with a negative sign. In every other case, including mode 0 (nearest-even), mode 4 (nearest, ties away) and the unused codes 5 to 7, the result is infinity of the operand's sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | EXP_W+FRAC_W+1 | Operand: sign, biased exponent, fraction |
| rm_i | input | 3 | Rounding mode, used only on the saturation path |
| res_o | output | EXP_W+FRAC_W+1 | Reciprocal estimate |
| flags_o | output | 5 | Exception flags {invalid, div-by-zero, overflow, underflow, inexact} |

## Verification
The rounding mode and the operand value reach the unit in the same evaluation. The key question is whether the mode leaks into a result where it must not matter. The bench applies a non-default mode to a normal operand and expects a result identical to the one produced under nearest-even. It also runs each saturating operand through all five defined modes and one unused code, for both signs, and judges each result against the R9 rule. Operands placed exactly at the exponents that yield computed exponents 0 and −1 confirm that the subnormal output path and the table lookup combine correctly.

// File: rtl/rec7_pkg.sv
package rec7_pkg;

    // Operand classes; the order is that of a conventional class mask
    typedef enum logic [3:0] {
        CLS_NEG_INF  = 4'd0,
        CLS_NEG_NORM = 4'd1,
        CLS_NEG_SUB  = 4'd2,
        CLS_NEG_ZERO = 4'd3,
        CLS_POS_ZERO = 4'd4,
        CLS_POS_SUB  = 4'd5,
        CLS_POS_NORM = 4'd6,
        CLS_POS_INF  = 4'd7,
        CLS_SNAN     = 4'd8,
        CLS_QNAN     = 4'd9
    } fp_class_e;

    // Rounding-mode codes that matter on the saturation path
    localparam logic [2:0] RM_TO_ZERO = 3'd1;
    localparam logic [2:0] RM_DOWN    = 3'd2;
    localparam logic [2:0] RM_UP      = 3'd3;

    // Flag vector bit positions
    localparam int FLAG_W = 5;
    localparam int FLG_NV = 4;
    localparam int FLG_DZ = 3;
    localparam int FLG_OF = 2;
    localparam int FLG_UF = 1;
    localparam int FLG_NX = 0;

    // Table geometry
    localparam int LUT_IDX_W  = 7;
    localparam int LUT_DEPTH  = 1 << LUT_IDX_W;
    localparam int LUT_SCALE  = 65536;
    localparam int LUT_OFFSET = 128;

    // Reciprocal of the midpoint of bucket idx, rounded, minus the hidden one
    function automatic logic [LUT_IDX_W-1:0] rec7_entry(input int idx);
        int den;
        int quo;
        den = 2 * LUT_DEPTH * 2 / 2 + 1 + 2 * idx;
        quo = (2 * LUT_SCALE + den) / (2 * den);
        return LUT_IDX_W'(quo - LUT_OFFSET);
    endfunction

endpackage

// File: rtl/rec7_classify.sv
module rec7_classify
    import rec7_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    output logic                  sgn_o,
    output logic [EXP_W-1:0]      exp_o,
    output logic [FRAC_W-1:0]     frac_o,
    output logic                  sub_o,
    output fp_class_e             cls_o
);

    logic exp_max;
    logic exp_zero;
    logic frac_zero;

    assign sgn_o  = op_i[EXP_W+FRAC_W];
    assign exp_o  = op_i[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_o = op_i[FRAC_W-1:0];

    assign exp_max   = &exp_o;
    assign exp_zero  = ~|exp_o;
    assign frac_zero = ~|frac_o;

    always_comb begin
        unique case ({exp_max, exp_zero})
            2'b10: begin
                if (frac_zero)
                    cls_o = sgn_o ? CLS_NEG_INF : CLS_POS_INF;
                else if (frac_o[FRAC_W-1])
                    cls_o = CLS_QNAN;
                else
                    cls_o = CLS_SNAN;
            end
            2'b01: begin
                if (frac_zero)
                    cls_o = sgn_o ? CLS_NEG_ZERO : CLS_POS_ZERO;
                else
                    cls_o = sgn_o ? CLS_NEG_SUB : CLS_POS_SUB;
            end
            default: cls_o = sgn_o ? CLS_NEG_NORM : CLS_POS_NORM;
        endcase
    end

    assign sub_o = (cls_o == CLS_NEG_SUB) || (cls_o == CLS_POS_SUB);

endmodule

// File: rtl/rec7_normalize.sv
module rec7_normalize #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int LZ_W   = $clog2(FRAC_W + 1),
    parameter int XW     = EXP_W + 2
) (
    input  logic [EXP_W-1:0]     exp_i,
    input  logic [FRAC_W-1:0]    frac_i,
    input  logic                 sub_i,
    output logic [LZ_W-1:0]      lz_o,
    output logic signed [XW-1:0] nexp_o,
    output logic [FRAC_W-1:0]    nfrac_o
);

    logic              found;
    logic [FRAC_W-1:0] aligned;
    logic [FRAC_W-1:0] dropped;

    // Leading-zero count, MSB first
    always_comb begin
        lz_o  = '0;
        found = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (frac_i[i])
                    found = 1'b1;
                else
                    lz_o = lz_o + LZ_W'(1);
            end
        end
    end

    assign aligned = frac_i << lz_o;
    assign dropped = aligned << 1;

    always_comb begin
        if (sub_i) begin
            nexp_o  = -$signed({{(XW-LZ_W){1'b0}}, lz_o});
            nfrac_o = dropped;
        end else begin
            nexp_o  = $signed({2'b00, exp_i});
            nfrac_o = frac_i;
        end
    end

    // R6
    always_comb begin
        if (!$isunknown(frac_i) && !$isunknown(sub_i)) begin
            if (sub_i && (frac_i != '0)) begin
                norm_lead_chk: assert (aligned[FRAC_W-1] == 1'b1)
                    else $error("normaliser left a zero in the leading position");
            end
        end
    end

endmodule

// File: rtl/rec7_lut.sv
module rec7_lut
    import rec7_pkg::*;
(
    input  logic [LUT_IDX_W-1:0] idx_i,
    output logic [LUT_IDX_W-1:0] val_o
);

    logic [LUT_IDX_W-1:0] entries [LUT_DEPTH];

    for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_entry
        localparam logic [LUT_IDX_W-1:0] ENTRY = rec7_entry(g);
        assign entries[g] = ENTRY;
    end

    assign val_o = entries[idx_i];

endmodule

// File: rtl/rec7_estimator.sv
module rec7_estimator
    import rec7_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    input  logic [2:0]            rm_i,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic [4:0]            flags_o
);

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int XW     = EXP_W + 2;
    localparam int LZ_W   = $clog2(FRAC_W + 1);
    localparam int PAD_W  = FRAC_W - LUT_IDX_W;

    localparam logic [EXP_W-1:0]  EXP_ONES  = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0]  EXP_TOP   = {{(EXP_W-1){1'b1}}, 1'b0};
    localparam logic [FRAC_W-1:0] FRAC_NONE = {FRAC_W{1'b0}};
    localparam logic [FRAC_W-1:0] FRAC_ALL  = {FRAC_W{1'b1}};
    localparam logic [WORD_W-1:0] CANON_NAN =
        {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic signed [XW-1:0] EXP_PIVOT = XW'(2 * BIAS - 1);
    localparam logic signed [XW-1:0] EXP_MINUS1 = {XW{1'b1}};

    logic                  sgn;
    logic [EXP_W-1:0]      exp_f;
    logic [FRAC_W-1:0]     frac_f;
    logic                  is_sub;
    fp_class_e             cls;
    logic [LZ_W-1:0]       lz;
    logic signed [XW-1:0]  nexp;
    logic [FRAC_W-1:0]     nfrac;
    logic [LUT_IDX_W-1:0]  lut_val;
    logic signed [XW-1:0]  mid_exp;
    logic [FRAC_W-1:0]     mant_est;
    logic                  too_small;
    logic                  keep_finite;

    rec7_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .op_i   (op_i),
        .sgn_o  (sgn),
        .exp_o  (exp_f),
        .frac_o (frac_f),
        .sub_o  (is_sub),
        .cls_o  (cls)
    );

    rec7_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .LZ_W(LZ_W), .XW(XW)) u_norm (
        .exp_i   (exp_f),
        .frac_i  (frac_f),
        .sub_i   (is_sub),
        .lz_o    (lz),
        .nexp_o  (nexp),
        .nfrac_o (nfrac)
    );

    rec7_lut u_lut (
        .idx_i (nfrac[FRAC_W-1 -: LUT_IDX_W]),
        .val_o (lut_val)
    );

    assign mid_exp   = EXP_PIVOT - nexp;
    assign mant_est  = {lut_val, {PAD_W{1'b0}}};
    assign too_small = is_sub && (lz > LZ_W'(1));

    always_comb begin
        keep_finite = (rm_i == RM_TO_ZERO)
                   || ((rm_i == RM_DOWN) && !sgn)
                   || ((rm_i == RM_UP) && sgn);
    end

    // Result selection by operand class
    always_comb begin
        res_o   = '0;
        flags_o = '0;
        unique case (cls)
            CLS_SNAN: begin
                res_o           = CANON_NAN;
                flags_o[FLG_NV] = 1'b1;
            end
            CLS_QNAN: begin
                res_o = CANON_NAN;
            end
            CLS_NEG_INF, CLS_POS_INF: begin
                res_o = {sgn, {EXP_W{1'b0}}, FRAC_NONE};
            end
            CLS_NEG_ZERO, CLS_POS_ZERO: begin
                res_o           = {sgn, EXP_ONES, FRAC_NONE};
                flags_o[FLG_DZ] = 1'b1;
            end
            CLS_NEG_SUB, CLS_POS_SUB, CLS_NEG_NORM, CLS_POS_NORM: begin
                if (too_small) begin
                    flags_o[FLG_OF] = 1'b1;
                    flags_o[FLG_NX] = 1'b1;
                    if (keep_finite)
                        res_o = {sgn, EXP_TOP, FRAC_ALL};
                    else
                        res_o = {sgn, EXP_ONES, FRAC_NONE};
                end else if (mid_exp == '0) begin
                    res_o = {sgn, {EXP_W{1'b0}}, 1'b1, mant_est[FRAC_W-1:1]};
                end else if (mid_exp == EXP_MINUS1) begin
                    res_o = {sgn, {EXP_W{1'b0}}, 2'b01, mant_est[FRAC_W-1:2]};
                end else begin
                    res_o = {sgn, mid_exp[EXP_W-1:0], mant_est};
                end
            end
            default: begin
                res_o   = CANON_NAN;
                flags_o = '0;
            end
        endcase
    end

    always_comb begin
        if (!$isunknown(op_i) && !$isunknown(rm_i)) begin
            // R2
            if (op_i[WORD_W-2:0] == '0) begin
                zero_to_inf_chk: assert ((res_o == {op_i[WORD_W-1], EXP_ONES, FRAC_NONE})
                                         && (flags_o == 5'b01000))
                    else $error("zero operand did not give a signed infinity");
            end
            // R3
            if ((res_o[WORD_W-2:FRAC_W] == EXP_ONES) && (res_o[FRAC_W-1:0] != '0)) begin
                nan_canon_chk: assert (res_o == CANON_NAN)
                    else $error("NaN result is not canonical");
            end
            // R9
            overflow_pair_chk: assert (flags_o[FLG_OF] == flags_o[FLG_NX])
                else $error("overflow and inexact disagree");
            // R1
            if (!((res_o[WORD_W-2:FRAC_W] == EXP_ONES) && (res_o[FRAC_W-1:0] != '0))) begin
                sign_keep_chk: assert (res_o[WORD_W-1] == op_i[WORD_W-1])
                    else $error("non-NaN result lost the operand sign");
            end
            // R7
            if ((res_o[WORD_W-2:FRAC_W] == '0) && (res_o[FRAC_W-1:0] != '0)) begin
                sub_lead_chk: assert (res_o[FRAC_W-1] || res_o[FRAC_W-2])
                    else $error("subnormal result lacks the shifted-in one");
            end
            // R2
            flags_count_chk: assert ($countones(flags_o) <= 2)
                else $error("too many flags at once");
        end
    end

endmodule

// File: tb/sim_rec7_estimator.sv
module sim_rec7_estimator;

    localparam real HALF_NS   = 2.5;
    localparam int  WATCH_CYC = 20000;

    typedef struct packed {
        logic [31:0] op;
        logic [2:0]  rm;
        logic [31:0] res;
        logic [4:0]  flg;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{32'h7F800000, 3'd0, 32'h00000000, 5'h00, 8'd1},  // R1 +inf
        '{32'hFF800000, 3'd0, 32'h80000000, 5'h00, 8'd1},  // R1 -inf
        '{32'h00000000, 3'd0, 32'h7F800000, 5'h08, 8'd2},  // R2 +0
        '{32'h80000000, 3'd3, 32'hFF800000, 5'h08, 8'd2},  // R2 -0
        '{32'h7F800001, 3'd0, 32'h7FC00000, 5'h10, 8'd3},  // R3 sNaN
        '{32'hFFC00000, 3'd0, 32'h7FC00000, 5'h00, 8'd3},  // R3 qNaN
        '{32'h3F800000, 3'd0, 32'h3F7F0000, 5'h00, 8'd4},  // R4 1.0
        '{32'h3F800000, 3'd3, 32'h3F7F0000, 5'h00, 8'd4},  // R4 mode ignored
        '{32'h3F800000, 3'd1, 32'h3F7F0000, 5'h00, 8'd4},  // R4 mode ignored
        '{32'hBFC00000, 3'd0, 32'hBF2A0000, 5'h00, 8'd4},  // R4 -1.5
        '{32'h3F8FFFFF, 3'd0, 32'h3F640000, 5'h00, 8'd4},  // R4 low bits ignored
        '{32'h407F0000, 3'd0, 32'h3E800000, 5'h00, 8'd5},  // R5 entry 127
        '{32'h3F890000, 3'd0, 32'h3F6E0000, 5'h00, 8'd5},  // R5 entry 9
        '{32'h00400000, 3'd0, 32'h7EFF0000, 5'h00, 8'd6},  // R6 lz 0
        '{32'h00300000, 3'd0, 32'h7F2A0000, 5'h00, 8'd6},  // R6 lz 1
        '{32'h80300000, 3'd2, 32'hFF2A0000, 5'h00, 8'd6},  // R6 lz 1 negative
        '{32'h7E800000, 3'd0, 32'h007F8000, 5'h00, 8'd7},  // R7 shift by one
        '{32'hFEC00000, 3'd0, 32'h80550000, 5'h00, 8'd7},  // R7 negative
        '{32'h7F000000, 3'd0, 32'h003FC000, 5'h00, 8'd8},  // R8 shift by two
        '{32'h7F7F0000, 3'd0, 32'h00200000, 5'h00, 8'd8},  // R8 entry 127
        '{32'h00100000, 3'd0, 32'h7F800000, 5'h05, 8'd9},  // R9 + nearest-even
        '{32'h00100000, 3'd1, 32'h7F7FFFFF, 5'h05, 8'd9},  // R9 + toward zero
        '{32'h00100000, 3'd2, 32'h7F7FFFFF, 5'h05, 8'd9},  // R9 + down
        '{32'h00100000, 3'd3, 32'h7F800000, 5'h05, 8'd9},  // R9 + up
        '{32'h00100000, 3'd4, 32'h7F800000, 5'h05, 8'd9},  // R9 + nearest-max
        '{32'h00100000, 3'd6, 32'h7F800000, 5'h05, 8'd9},  // R9 + unused code
        '{32'h80000001, 3'd0, 32'hFF800000, 5'h05, 8'd9},  // R9 - nearest-even
        '{32'h80000001, 3'd1, 32'hFF7FFFFF, 5'h05, 8'd9},  // R9 - toward zero
        '{32'h80000001, 3'd2, 32'hFF800000, 5'h05, 8'd9},  // R9 - down
        '{32'h80000001, 3'd3, 32'hFF7FFFFF, 5'h05, 8'd9},  // R9 - up
        '{32'h80000001, 3'd4, 32'hFF800000, 5'h05, 8'd9},  // R9 - nearest-max
        '{32'h80000001, 3'd7, 32'hFF800000, 5'h05, 8'd9},  // R9 - unused code
        '{32'h001FFFFF, 3'd1, 32'h7F7FFFFF, 5'h05, 8'd9}   // R9 lz 2 boundary
    };

    logic        clk = 1'b0;
    logic [31:0] op;
    logic [2:0]  rm;
    logic [31:0] res;
    logic [4:0]  flg;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #(HALF_NS) clk = ~clk;

    rec7_estimator #(.EXP_W(8), .FRAC_W(23)) u0 (
        .op_i    (op),
        .rm_i    (rm),
        .res_o   (res),
        .flags_o (flg)
    );

    task automatic apply(input logic [31:0] o, input logic [2:0] m);
        @(posedge clk);
        op = o;
        rm = m;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] er, input logic [4:0] ef);
        n_cmp++;
        if (res !== er || flg !== ef) begin
            n_bad++;
            $display("FAIL %s: op=%h rm=%0d res=%h flags=%b expected res=%h flags=%b",
                     tag, op, rm, res, flg, er, ef);
        end
    endtask

    initial begin
        logic [6:0] prev;
        logic [6:0] cur;
        op = '0;
        rm = '0;
        // Vector table
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].op, VECS[k].rm);
            check($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].res, VECS[k].flg);
        end
        // R5 sweep: fixed exponent, every table index; shape and endpoints
        prev = 7'h7F;
        for (int i = 0; i < 128; i++) begin
            apply({1'b0, 8'd127, 7'(i), 16'h0000}, 3'd0);
            cur = res[22:16];
            n_cmp++;
            if (res[31:23] != 9'd126 || res[15:0] != 16'h0 || flg != 5'h0 || cur > prev) begin
                n_bad++;
                $display("FAIL R5 index %0d: res=%h flags=%b expected exp 126, low zero, entry <= %0d",
                         i, res, flg, prev);
            end
            if (i == 0) check("R5 entry0", 32'h3F7F0000, 5'h00);
            if (i == 127) check("R5 entry127", 32'h3F000000, 5'h00);
            prev = cur;
        end
        // R4 exponent extremes on the normal path
        apply(32'h00800000, 3'd0);   // smallest normal: exp 253-1
        check("R4 min normal", 32'h7E7F0000, 5'h00);
        apply(32'h7E000000, 3'd2);   // exp 252 gives exponent 1
        check("R4 exp one", 32'h00FF0000, 5'h00);
        // R3 sNaN with negative sign and full payload
        apply(32'hFFBFFFFF, 3'd0);
        check("R3 neg sNaN", 32'h7FC00000, 5'h10);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCH_CYC) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule